// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block is a cycle-level digital model of a four-section clock skew matrix. It runs on a fast timing clock whose period is one time unit (TU). A phase counter cycles through `TU_PER_PERIOD` time units, and each pass of the counter is one period of the nominal output clock. The zero-skew waveform, high for the first half of the count, is the reference that every other waveform is measured against.

Each of the four sections reads two three-level function selects and drives a pair of outputs that always carry the same waveform. Depending on its nine-way function code, a section produces a square wave shifted by a signed number of time units, a divided clock or an inverted clock. A new code takes effect only at the next phase-counter wrap, so a change never produces a short pulse.

A three-level test select can bypass the phase counter. The reference input then drives the outputs directly, and each section applies only its divide or invert function.

Top module: `skew_matrix_top`

## Requirements
- R1: Each select is 2 bits: 00 is Low, 01 is Mid, 10 is High, and 11 is also read as Mid. A section's code is written XY, where X is the level on its `fsel_hi` pair and Y the level on its `fsel_lo` pair. The code index is 3*X+Y, with Low=0, Mid=1, High=2.
- R2: The phase counter is 0 while reset is high and steps by one on each clock after reset, returning from TU_PER_PERIOD-1 to 0. All outputs stay low until the first such wrap.
- R3: In sections 0 and 1, codes LL, LM, LH, ML, MM, MH, HL, HM, HH give skews k of -4, -3, -2, -1, 0, +1, +2, +3, +4 TU. A skewed output is high exactly when (phase - k) mod TU_PER_PERIOD < TU_PER_PERIOD/2. With code MM, section 0 therefore carries the reference.
- R4: In sections 2 and 3, codes LM, LH, ML, MM, MH, HL, HM give skews of -6, -4, -2, 0, +2, +4, +6 TU, with the same high window as in R3.
- R5: In sections 2 and 3, code LL gives a divide-by-2 clock. Counting periods from 0 at the first wrap, it is high for the whole of every even period.
- R6: In section 2, code HH gives a divide-by-4 clock that is high in periods whose count mod 4 is 0 or 1.
- R7: In section 3, code HH gives the inverted reference, which is high when the phase is at least TU_PER_PERIOD/2.
- R8: Section s drives `clk_out[2s]` and `clk_out[2s+1]`, and the two bits are always equal.
- R9: Select changes are captured only on the clock where the phase counter wraps. Until then, each output keeps following its previous code.
- R10: When `test_sel` is not Low, the outputs bypass the phase counter. Skew codes pass `ref_in` unchanged and the invert code gives its complement. For the divide codes, a counter of rising edges of `ref_in`, sampled on the timing clock since reset, drives the output: bit 0 of the count for divide-by-2 and bit 1 for divide-by-4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one period per time unit |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock, used directly in bypass mode |
| test_sel | input | 2 | Three-level test select; Low is normal operation |
| fsel_hi | input | 8 | First-letter function select, 2 bits per section |
| fsel_lo | input | 8 | Second-letter function select, 2 bits per section |
| clk_out | output | 8 | Output pairs, bits 2s and 2s+1 for section s |

## Verification
On every cycle, the assertions check the following:
- the phase counter steps by one and wraps;
- a section's latched code changes only after a wrap;
- outputs stay quiet before the first wrap;
- a skewed output rises only at its own phase point, and a divided output rises only at a period boundary;
- the reference edge counter advances exactly on sampled rising edges.

Only the bench scenarios can show the rest. These are the absolute mapping of all nine codes to skews and functions in each section group, the 50% high window, the reading of 11 as Mid, the deferral of a change made mid-period, and the bypass waveforms for several reference patterns.

// File: rtl/skew_pkg.sv
package skew_pkg;

    localparam int NUM_SECT = 4;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_HIGH = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        FN_SKEW = 2'd0,
        FN_DIV2 = 2'd1,
        FN_DIV4 = 2'd2,
        FN_INV  = 2'd3
    } fn_e;

    typedef struct packed {
        fn_e              fn;
        logic signed [3:0] skew;
    } sect_cfg_t;

    // 11 is read as the floating (Mid) level
    function automatic lvl_e to_level(input logic [1:0] pin);
        case (pin)
            2'b00:   return LVL_LOW;
            2'b10:   return LVL_HIGH;
            default: return LVL_MID;
        endcase
    endfunction

    function automatic logic [3:0] code_index(input logic [1:0] hi, input logic [1:0] lo);
        logic [3:0] h;
        logic [3:0] l;
        h = {2'b00, to_level(hi)};
        l = {2'b00, to_level(lo)};
        return h * 4'd3 + l;
    endfunction

    // Sections 0/1: unit steps. Sections 2/3: double steps, ends are special.
    function automatic sect_cfg_t decode_cfg(input int sect, input logic [3:0] idx);
        sect_cfg_t c;
        int        k;
        k      = int'(idx) - 4;
        c.fn   = FN_SKEW;
        c.skew = '0;
        if (sect < 2) begin
            c.skew = 4'(k);
        end else if (idx == 4'd0) begin
            c.fn = FN_DIV2;
        end else if (idx == 4'd8) begin
            c.fn = (sect == 2) ? FN_DIV4 : FN_INV;
        end else begin
            c.skew = 4'(2 * k);
        end
        return c;
    endfunction

endpackage

// File: rtl/skew_phase_gen.sv
module skew_phase_gen #(
    parameter int N    = 16,
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            wrap,
    output logic            started,
    output logic [1:0]      pcount
);

    assign wrap = (phase == PH_W'(N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= '0;
            started <= 1'b0;
            pcount  <= '0;
        end else if (wrap) begin
            phase   <= '0;
            started <= 1'b1;
            pcount  <= started ? pcount + 2'd1 : 2'd0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> (phase == $past(phase) + 1'b1));

    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (phase == '0 && started));

endmodule

// File: rtl/skew_ref_div.sv
module skew_ref_div (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_in,
    output logic [1:0] rdiv
);

    logic ref_q;
    logic ref_rise;

    assign ref_rise = ref_in && !ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
            rdiv  <= '0;
        end else begin
            ref_q <= ref_in;
            if (ref_rise) rdiv <= rdiv + 2'd1;
        end
    end

    assert_refdiv_count_R10: assert property (@(posedge clk) disable iff (rst)
        ref_rise |=> (rdiv == $past(rdiv) + 2'd1));

    assert_refdiv_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !ref_rise |=> $stable(rdiv));

endmodule

// File: rtl/skew_section.sv
module skew_section
    import skew_pkg::*;
#(
    parameter int SECT = 0,
    parameter int N    = 16,
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wrap,
    input  logic            started,
    input  logic [PH_W-1:0] phase,
    input  logic [1:0]      pcount,
    input  logic            bypass,
    input  logic            ref_in,
    input  logic [1:0]      rdiv,
    input  logic [1:0]      sel_hi,
    input  logic [1:0]      sel_lo,
    output logic            wave
);

    sect_cfg_t cfg;
    logic      norm_wave;
    logic      byp_wave;
    int        rel;

    // Code is captured only at the period boundary
    always_ff @(posedge clk) begin
        if (rst) cfg <= decode_cfg(SECT, code_index(2'b01, 2'b01));
        else if (wrap) cfg <= decode_cfg(SECT, code_index(sel_hi, sel_lo));
    end

    always_comb begin
        rel       = (int'(phase) - int'($signed(cfg.skew)) + 2 * N) % N;
        norm_wave = 1'b0;
        byp_wave  = 1'b0;
        unique case (cfg.fn)
            FN_SKEW: begin
                norm_wave = (rel < N / 2);
                byp_wave  = ref_in;
            end
            FN_DIV2: begin
                norm_wave = !pcount[0];
                byp_wave  = rdiv[0];
            end
            FN_DIV4: begin
                norm_wave = !pcount[1];
                byp_wave  = rdiv[1];
            end
            FN_INV: begin
                norm_wave = (int'(phase) >= N / 2);
                byp_wave  = !ref_in;
            end
        endcase
        wave = bypass ? byp_wave : (started && norm_wave);
    end

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cfg));

    assert_quiet_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !started) |-> !wave);

    assert_skew_edge_R3: assert property (@(posedge clk) disable iff (rst)
        (!bypass && $past(!bypass) && $past(started) && cfg == $past(cfg)
         && cfg.fn == FN_SKEW && $rose(wave)) |-> (rel == 0));

    assert_div_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (!bypass && $past(!bypass) && $past(started) && cfg == $past(cfg)
         && (cfg.fn == FN_DIV2 || cfg.fn == FN_DIV4) && $rose(wave)) |-> (phase == '0));

endmodule

// File: rtl/skew_matrix_top.sv
module skew_matrix_top
    import skew_pkg::*;
#(
    parameter int TU_PER_PERIOD = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ref_in,
    input  logic [1:0]            test_sel,
    input  logic [2*NUM_SECT-1:0] fsel_hi,
    input  logic [2*NUM_SECT-1:0] fsel_lo,
    output logic [2*NUM_SECT-1:0] clk_out
);

    localparam int PH_W = $clog2(TU_PER_PERIOD);

    logic [PH_W-1:0] phase;
    logic            wrap;
    logic            started;
    logic [1:0]      pcount;
    logic [1:0]      rdiv;
    logic            bypass;

    assign bypass = (to_level(test_sel) != LVL_LOW);

    skew_phase_gen #(.N(TU_PER_PERIOD), .PH_W(PH_W)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .wrap    (wrap),
        .started (started),
        .pcount  (pcount)
    );

    skew_ref_div u_rdiv (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_in),
        .rdiv   (rdiv)
    );

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        logic wave;
        skew_section #(.SECT(s), .N(TU_PER_PERIOD), .PH_W(PH_W)) u_sect (
            .clk     (clk),
            .rst     (rst),
            .wrap    (wrap),
            .started (started),
            .phase   (phase),
            .pcount  (pcount),
            .bypass  (bypass),
            .ref_in  (ref_in),
            .rdiv    (rdiv),
            .sel_hi  (fsel_hi[2*s +: 2]),
            .sel_lo  (fsel_lo[2*s +: 2]),
            .wave    (wave)
        );
        // R8: both outputs of a pair carry the section waveform
        assign clk_out[2*s +: 2] = {2{wave}};
    end

endmodule

// File: tb/sim_skew_matrix_top.sv
`timescale 1ns/1ps
module sim_skew_matrix_top;

    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_in = 1'b0;
    logic [1:0] test_sel = 2'b00;
    logic [7:0] fsel_hi = 8'h55;
    logic [7:0] fsel_lo = 8'h55;
    logic [7:0] clk_out;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string scen = "R2";

    int         e = 0;
    int         ref_cnt = 0;
    logic       ref_seen = 1'b0;
    logic [1:0] lat_hi [4];
    logic [1:0] lat_lo [4];

    always #10 clk = ~clk;

    skew_matrix_top #(.TU_PER_PERIOD(N)) u0 (
        .clk(clk), .rst(rst), .ref_in(ref_in), .test_sel(test_sel),
        .fsel_hi(fsel_hi), .fsel_lo(fsel_lo), .clk_out(clk_out)
    );

    // Reference model state: edge count, latched codes (R9), ref edge count (R10)
    always @(posedge clk) begin
        if (rst) begin
            e = 0; ref_cnt = 0; ref_seen = 1'b0;
            for (int s = 0; s < 4; s++) begin lat_hi[s] = 2'b01; lat_lo[s] = 2'b01; end
        end else begin
            e = e + 1;
            if (e % N == 0)
                for (int s = 0; s < 4; s++) begin
                    lat_hi[s] = fsel_hi[2*s +: 2];
                    lat_lo[s] = fsel_lo[2*s +: 2];
                end
            if (ref_in && !ref_seen) ref_cnt = ref_cnt + 1;
            ref_seen = ref_in;
        end
    end

    // R1 encoding
    function automatic int lvl(input logic [1:0] p);
        return (p == 2'b00) ? 0 : (p == 2'b10) ? 2 : 1;
    endfunction

    task automatic check_sect(input int s);
        int    code, k, kind, ph, c;
        bit    started, byp;
        logic  exp_v;
        string tag;
        code = 3 * lvl(lat_hi[s]) + lvl(lat_lo[s]);
        ph = e % N; started = (e >= N); c = e / N - 1;
        byp = (lvl(test_sel) != 0);
        k = 0; kind = 0;
        if (s < 2) k = code - 4;
        else if (code == 0) kind = 1;
        else if (code == 8) kind = (s == 2) ? 2 : 3;
        else k = 2 * (code - 4);
        if (byp) begin
            tag = "R10";
            case (kind)
                0: exp_v = ref_in;
                1: exp_v = (ref_cnt % 2) != 0;
                2: exp_v = ((ref_cnt / 2) % 2) != 0;
                default: exp_v = !ref_in;
            endcase
        end else if (!started) begin
            tag = "R2"; exp_v = 1'b0;
        end else begin
            case (kind)
                0: begin tag = (s < 2) ? "R3" : "R4"; exp_v = ((ph - k + 2 * N) % N) < N / 2; end
                1: begin tag = "R5"; exp_v = (c % 2) == 0; end
                2: begin tag = "R6"; exp_v = (c % 4) < 2; end
                default: begin tag = "R7"; exp_v = ph >= N / 2; end
            endcase
        end
        n_chk++;
        if (clk_out[2*s] !== exp_v) begin
            n_fail++;
            $display("FAIL %s [%s] sect %0d e=%0d: got %b expected %b", tag, scen, s, e, clk_out[2*s], exp_v);
        end
        n_chk++;
        if (clk_out[2*s+1] !== clk_out[2*s]) begin
            n_fail++;
            $display("FAIL R8 [%s] sect %0d pair: got %b expected %b", scen, s, clk_out[2*s+1], clk_out[2*s]);
        end
    endtask

    task automatic step(input logic nref);
        @(posedge clk);
        #4 ref_in = nref;
        #2;
        for (int s = 0; s < 4; s++) check_sect(s);
    endtask

    task automatic run(input int cycles);
        for (int t = 0; t < cycles; t++) step(1'b0);
    endtask

    task automatic run_ref(input int cycles);
        for (int t = 0; t < cycles; t++) step(((t % 7) < 3) ? 1'b1 : 1'b0);
    endtask

    task automatic set_all(input logic [1:0] hi, input logic [1:0] lo);
        fsel_hi = {4{hi}};
        fsel_lo = {4{lo}};
    endtask

    function automatic logic [1:0] pin_of(input int l);
        return (l == 0) ? 2'b00 : (l == 2) ? 2'b10 : 2'b01;
    endfunction

    initial begin
        // Reset state and quiet period before first wrap (R2)
        scen = "R2 reset";
        run(3);
        rst = 1'b0;
        scen = "R2 pre-wrap";
        run(N - 1);

        // All nine codes on every section, changed mid-period (R9)
        for (int i = 0; i < 9; i++) begin
            scen = "R9 sweep";
            run(5);
            set_all(pin_of(i / 3), pin_of(i % 3));
            run(3 * N);
        end

        // 11 read as Mid (R1)
        scen = "R1 alias";
        set_all(2'b11, 2'b11);
        run(2 * N);
        set_all(2'b11, 2'b00);
        run(2 * N);
        set_all(2'b10, 2'b11);
        run(2 * N);

        // Different code per section
        for (int i = 0; i < 9; i++) begin
            scen = "R8 mixed";
            for (int s = 0; s < 4; s++) begin
                int cd;
                cd = (i + 2 * s + 1) % 9;
                fsel_hi[2*s +: 2] = pin_of(cd / 3);
                fsel_lo[2*s +: 2] = pin_of(cd % 3);
            end
            run(2 * N);
        end

        // Bypass via Mid and High test levels (R10)
        scen = "R10 bypass";
        for (int m = 1; m < 3; m++) begin
            test_sel = pin_of(m);
            for (int j = 0; j < 3; j++) begin
                set_all(pin_of((4 * j) / 3), pin_of((4 * j) % 3));
                run_ref(3 * N);
            end
        end
        test_sel = 2'b11;
        run_ref(2 * N);

        // Back to normal operation
        scen = "R3 resume";
        test_sel = 2'b00;
        set_all(2'b01, 2'b10);
        run(3 * N);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(100000 * 20);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule